// File: doc/BRIEF.md
# Time-Slot Interchange Switch Core

This block moves 8-bit channels between a set of parallel input streams and a set of parallel output streams. A frame is a fixed run of channel slots. Each clock cycle is one slot, and in that slot every input stream presents one byte. These bytes are stored in a data memory that has three frame-sized banks, which are used in rotation. A frame-start pulse forces the slot counter back to channel 0.

For each output stream and channel there is one connection entry. It holds a 3-bit mode and a low word. The mode decides what the output carries in that slot:
- data switched from a named source stream and channel, with either constant or variable delay;
- a byte written by the processor;
- a fixed test byte;
- the idle byte;
- nothing, with the output driver disabled.

A processor port writes and reads the connection entries. A write takes effect from the next slot, and every entry changes as a whole word.

Each output byte and its enable are registered. They appear in the cycle that follows the slot they belong to.

Top module: `tsi_switch_core`

## Requirements
- R1: The slot index advances by one each cycle and wraps to 0 after NUM_CHANS-1. When the index wraps, the bank index (0, 1, 2, in rotation) advances.
- R2: R1 continued: when `frame_sync` is high, that cycle is channel 0. It also advances the bank, unless the index would have wrapped to 0 anyway.
- R3: In every slot, the byte of each input stream is stored in the current bank at that stream and channel. Each output is registered and appears in the cycle after its slot.
- R4: Mode 3'b111 sets that stream's `out_en` low and its byte to 8'h00 for that slot only.
- R5: Mode 3'b100 outputs bits [7:0] of the entry's low word in every frame until the entry is rewritten.
- R6: Mode 3'b101 outputs a test byte: 8'h55 on even channels and 8'hAA on odd channels.
- R7: Mode 3'b001 (constant delay) outputs the byte that the source slot stored two frames earlier. This is the bank that follows the current bank in the rotation.
- R8: Mode 3'b000 (variable delay) works as follows:
  - if source channel + 3 <= destination channel, it outputs the byte stored earlier in the current frame;
  - otherwise it outputs the byte from the previous frame.
- R9: In the switched modes, low-word bits [CW-1:0] give the source channel and bits [CW+SW-1:CW] give the source stream. Any number of outputs may name the same source.
- R10: Modes 3'b010, 3'b011 and 3'b110 output 8'hFF with `out_en` high.
- R11: A processor write to the entry at address {stream, channel} takes effect from the next slot on. If the write falls in that entry's own slot, that slot still uses the old contents.
- R12: A processor read returns the entry's mode and low word in the next cycle. If a write to the same address happens in the same cycle, the read returns the old contents.
- R13: After reset:
  - `out_en` and `out_data` are 0;
  - every entry is mode 3'b111 with a low word of 0;
  - the data memory holds zeros;
  - the slot and bank indices are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | High in the slot that starts a frame |
| in_data | input | NUM_STREAMS*8 | One byte per input stream for the current slot |
| cpu_wr | input | 1 | Write the connection entry at `cpu_addr` |
| cpu_rd | input | 1 | Read the connection entry at `cpu_addr` |
| cpu_addr | input | SW+CW | Entry address {stream, channel} |
| cpu_wmode | input | 3 | Mode to write |
| cpu_wlow | input | LW | Low word to write |
| cpu_rmode | output | 3 | Mode read back |
| cpu_rlow | output | LW | Low word read back |
| out_data | output | NUM_STREAMS*8 | One byte per output stream |
| out_en | output | NUM_STREAMS | Output driver enable, one bit per stream |

## Verification
Every output byte and enable is due one clock edge after its slot, which is the edge that closes the slot. Processor read data is due one edge after the request. The bench works out what it expects from its own model while it drives a slot. It then waits for the closing edge and samples 1 ns later. Only after that sample does it update the model with that slot's stores and writes. As a result, "old entry in its own slot" and "store before read" fall out of the order of the bench's own steps.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  typedef logic [2:0] tsi_mode_t;
  typedef logic [1:0] bank_t;

  localparam tsi_mode_t MODE_VAR   = 3'b000;
  localparam tsi_mode_t MODE_CONST = 3'b001;
  localparam tsi_mode_t MODE_CPU   = 3'b100;
  localparam tsi_mode_t MODE_TEST  = 3'b101;
  localparam tsi_mode_t MODE_OFF   = 3'b111;

  localparam logic [7:0] IDLE_BYTE = 8'hFF;
  localparam logic [7:0] TEST_EVEN = 8'h55;
  localparam logic [7:0] TEST_ODD  = 8'hAA;
  localparam int unsigned VAR_GAP  = 3;

  // rotation of the three frame banks
  function automatic bank_t bank_next(bank_t b);
    return (b == 2'd2) ? 2'd0 : b + 2'd1;
  endfunction

  function automatic bank_t bank_prev(bank_t b);
    return (b == 2'd0) ? 2'd2 : b - 2'd1;
  endfunction

  // variable delay: same frame only when the source lies far enough ahead
  function automatic bank_t var_bank(int unsigned src, int unsigned dst, bank_t cur);
    return (src + VAR_GAP <= dst) ? cur : bank_prev(cur);
  endfunction

  function automatic logic [7:0] test_byte(logic odd);
    return odd ? TEST_ODD : TEST_EVEN;
  endfunction

  function automatic logic is_unused(tsi_mode_t m);
    return (m == 3'b010) || (m == 3'b011) || (m == 3'b110);
  endfunction

endpackage

// File: rtl/tsi_slot_timer.sv
module tsi_slot_timer
  import tsi_pkg::*;
#(
  parameter int NUM_CHANS = 8,
  localparam int CW = (NUM_CHANS > 1) ? $clog2(NUM_CHANS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_sync,
  output logic [CW-1:0] slot_ch,
  output bank_t         slot_bank
);

  localparam logic [CW-1:0] LAST_CH = CW'(NUM_CHANS - 1);

  logic [CW-1:0] ch_q;
  bank_t         bank_q;
  logic          last_slot;

  always_comb begin
    slot_ch   = ch_q;
    slot_bank = bank_q;
    if (frame_sync) begin
      slot_ch = '0;
      if (ch_q != '0) slot_bank = bank_next(bank_q);
    end
  end

  assign last_slot = (slot_ch == LAST_CH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q   <= '0;
      bank_q <= 2'd0;
    end else begin
      ch_q   <= last_slot ? '0 : slot_ch + 1'b1;
      bank_q <= last_slot ? bank_next(slot_bank) : slot_bank;
    end
  end

endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
  import tsi_pkg::*;
#(
  parameter int NUM_STREAMS = 4,
  parameter int NUM_CHANS   = 8,
  localparam int CW = (NUM_CHANS > 1) ? $clog2(NUM_CHANS) : 1,
  localparam int SW = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  bank_t                    wr_bank,
  input  logic [CW-1:0]            wr_ch,
  input  logic [NUM_STREAMS*8-1:0] wr_data,
  input  logic [NUM_STREAMS*2-1:0] rd_bank,
  input  logic [NUM_STREAMS*SW-1:0] rd_st,
  input  logic [NUM_STREAMS*CW-1:0] rd_ch,
  output logic [NUM_STREAMS*8-1:0] rd_data
);

  logic [7:0] mem [3][NUM_STREAMS][NUM_CHANS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 3; b++)
        for (int s = 0; s < NUM_STREAMS; s++)
          for (int c = 0; c < NUM_CHANS; c++)
            mem[b][s][c] <= 8'h00;
    end else begin
      for (int s = 0; s < NUM_STREAMS; s++)
        mem[wr_bank][s][wr_ch] <= wr_data[s*8 +: 8];
    end
  end

  // one read port per output stream
  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_rd
    assign rd_data[s*8 +: 8] = mem[rd_bank[s*2 +: 2]][rd_st[s*SW +: SW]][rd_ch[s*CW +: CW]];
  end

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
  import tsi_pkg::*;
#(
  parameter int NUM_STREAMS = 4,
  parameter int NUM_CHANS   = 8,
  parameter int LW          = 8,
  localparam int CW    = (NUM_CHANS > 1) ? $clog2(NUM_CHANS) : 1,
  localparam int SW    = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
  localparam int AW    = SW + CW,
  localparam int DEPTH = 1 << AW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_wr,
  input  logic                      cpu_rd,
  input  logic [AW-1:0]             cpu_addr,
  input  tsi_mode_t                 cpu_wmode,
  input  logic [LW-1:0]             cpu_wlow,
  output tsi_mode_t                 cpu_rmode,
  output logic [LW-1:0]             cpu_rlow,
  input  logic [CW-1:0]             slot_ch,
  output logic [NUM_STREAMS*3-1:0]  ent_mode,
  output logic [NUM_STREAMS*LW-1:0] ent_low
);

  tsi_mode_t     mode_mem [DEPTH];
  logic [LW-1:0] low_mem  [DEPTH];

  // whole-word update at the slot edge: a slot never sees half an entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mode_mem[i] <= MODE_OFF;
        low_mem[i]  <= '0;
      end
      cpu_rmode <= '0;
      cpu_rlow  <= '0;
    end else begin
      if (cpu_wr) begin
        mode_mem[cpu_addr] <= cpu_wmode;
        low_mem[cpu_addr]  <= cpu_wlow;
      end
      if (cpu_rd) begin
        cpu_rmode <= mode_mem[cpu_addr];
        cpu_rlow  <= low_mem[cpu_addr];
      end
    end
  end

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_slot_rd
    assign ent_mode[s*3 +: 3]  = mode_mem[{SW'(s), slot_ch}];
    assign ent_low[s*LW +: LW] = low_mem[{SW'(s), slot_ch}];
  end

endmodule

// File: rtl/tsi_out_sel.sv
module tsi_out_sel
  import tsi_pkg::*;
#(
  parameter int CW = 3,
  parameter int SW = 2,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] slot_ch,
  input  bank_t         slot_bank,
  input  tsi_mode_t     mode,
  input  logic [LW-1:0] low,
  input  logic [7:0]    dm_byte,
  output bank_t         rd_bank,
  output logic [SW-1:0] rd_st,
  output logic [CW-1:0] rd_ch,
  output logic [7:0]    out_byte,
  output logic          out_en
);

  logic [7:0] nxt_byte;
  logic       nxt_en;

  assign rd_ch   = low[CW-1:0];
  assign rd_st   = low[CW +: SW];
  assign rd_bank = (mode == MODE_CONST) ? bank_next(slot_bank)
                                        : var_bank(32'(rd_ch), 32'(slot_ch), slot_bank);

  always_comb begin
    nxt_en   = 1'b1;
    nxt_byte = IDLE_BYTE;
    case (mode)
      MODE_VAR, MODE_CONST: nxt_byte = dm_byte;
      MODE_CPU:             nxt_byte = low[7:0];
      MODE_TEST:            nxt_byte = test_byte(slot_ch[0]);
      MODE_OFF: begin
        nxt_en   = 1'b0;
        nxt_byte = 8'h00;
      end
      default:              nxt_byte = IDLE_BYTE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_byte <= 8'h00;
      out_en   <= 1'b0;
    end else begin
      out_byte <= nxt_byte;
      out_en   <= nxt_en;
    end
  end

endmodule

// File: rtl/tsi_switch_core.sv
module tsi_switch_core
  import tsi_pkg::*;
#(
  parameter int NUM_STREAMS = 4,
  parameter int NUM_CHANS   = 8,
  localparam int CW = (NUM_CHANS > 1) ? $clog2(NUM_CHANS) : 1,
  localparam int SW = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
  localparam int AW = SW + CW,
  localparam int LW = (AW > 8) ? AW : 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_sync,
  input  logic [NUM_STREAMS*8-1:0] in_data,
  input  logic                     cpu_wr,
  input  logic                     cpu_rd,
  input  logic [AW-1:0]            cpu_addr,
  input  logic [2:0]               cpu_wmode,
  input  logic [LW-1:0]            cpu_wlow,
  output logic [2:0]               cpu_rmode,
  output logic [LW-1:0]            cpu_rlow,
  output logic [NUM_STREAMS*8-1:0] out_data,
  output logic [NUM_STREAMS-1:0]   out_en
);

  // named internal events, also watched by the bound checker
  logic [CW-1:0]             slot_ch;
  bank_t                     slot_bank;
  logic [NUM_STREAMS*3-1:0]  ent_mode;
  logic [NUM_STREAMS*LW-1:0] ent_low;
  logic [NUM_STREAMS*2-1:0]  dm_bank;
  logic [NUM_STREAMS*SW-1:0] dm_st;
  logic [NUM_STREAMS*CW-1:0] dm_ch;
  logic [NUM_STREAMS*8-1:0]  dm_byte;

  tsi_slot_timer #(.NUM_CHANS(NUM_CHANS)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .slot_ch    (slot_ch),
    .slot_bank  (slot_bank)
  );

  tsi_data_mem #(.NUM_STREAMS(NUM_STREAMS), .NUM_CHANS(NUM_CHANS)) u_dmem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_bank (slot_bank),
    .wr_ch   (slot_ch),
    .wr_data (in_data),
    .rd_bank (dm_bank),
    .rd_st   (dm_st),
    .rd_ch   (dm_ch),
    .rd_data (dm_byte)
  );

  tsi_conn_mem #(.NUM_STREAMS(NUM_STREAMS), .NUM_CHANS(NUM_CHANS), .LW(LW)) u_cmem (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_addr  (cpu_addr),
    .cpu_wmode (cpu_wmode),
    .cpu_wlow  (cpu_wlow),
    .cpu_rmode (cpu_rmode),
    .cpu_rlow  (cpu_rlow),
    .slot_ch   (slot_ch),
    .ent_mode  (ent_mode),
    .ent_low   (ent_low)
  );

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_out
    tsi_out_sel #(.CW(CW), .SW(SW), .LW(LW)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_ch   (slot_ch),
      .slot_bank (slot_bank),
      .mode      (ent_mode[s*3 +: 3]),
      .low       (ent_low[s*LW +: LW]),
      .dm_byte   (dm_byte[s*8 +: 8]),
      .rd_bank   (dm_bank[s*2 +: 2]),
      .rd_st     (dm_st[s*SW +: SW]),
      .rd_ch     (dm_ch[s*CW +: CW]),
      .out_byte  (out_data[s*8 +: 8]),
      .out_en    (out_en[s])
    );
  end

endmodule

// File: rtl/tsi_switch_core_chk.sv
module tsi_switch_core_chk
  import tsi_pkg::*;
#(
  parameter int NUM_STREAMS = 4,
  parameter int NUM_CHANS   = 8,
  localparam int CW = (NUM_CHANS > 1) ? $clog2(NUM_CHANS) : 1,
  localparam int SW = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
  localparam int AW = SW + CW,
  localparam int LW = (AW > 8) ? AW : 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      frame_sync,
  input logic [CW-1:0]             slot_ch,
  input logic [1:0]                slot_bank,
  input logic [NUM_STREAMS*3-1:0]  ent_mode,
  input logic [NUM_STREAMS*LW-1:0] ent_low,
  input logic [NUM_STREAMS*8-1:0]  out_data,
  input logic [NUM_STREAMS-1:0]    out_en
);

  localparam logic [CW-1:0] LAST_CH = CW'(NUM_CHANS - 1);

  logic          seen_q;
  logic [CW-1:0] prev_ch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q    <= 1'b0;
      prev_ch_q <= '0;
    end else begin
      seen_q    <= 1'b1;
      prev_ch_q <= slot_ch;
    end
  end

  // R1
  p_slot_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_ch == LAST_CH) |=> (slot_ch == '0));

  // R1
  p_slot_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !frame_sync && prev_ch_q != LAST_CH) |-> (slot_ch == prev_ch_q + 1'b1));

  // R1
  p_bank_turn_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_ch == LAST_CH) |=> (slot_bank == bank_next($past(slot_bank))));

  // R1
  p_bank_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_bank != 2'd3);

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_st
    // R4
    p_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_mode[s*3 +: 3] == MODE_OFF) |=> (!out_en[s] && out_data[s*8 +: 8] == 8'h00));

    // R10
    p_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_mode[s*3 +: 3] != MODE_OFF) |=> out_en[s]);

    // R10
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      is_unused(ent_mode[s*3 +: 3]) |=> (out_data[s*8 +: 8] == IDLE_BYTE));

    // R5
    p_cpu_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_mode[s*3 +: 3] == MODE_CPU) |=> (out_data[s*8 +: 8] == $past(ent_low[s*LW +: 8])));

    // R6
    p_test_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_mode[s*3 +: 3] == MODE_TEST) |=> (out_data[s*8 +: 8] == test_byte($past(slot_ch[0]))));
  end

endmodule

bind tsi_switch_core tsi_switch_core_chk #(
  .NUM_STREAMS (NUM_STREAMS),
  .NUM_CHANS   (NUM_CHANS)
) i_tsi_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_sync (frame_sync),
  .slot_ch    (slot_ch),
  .slot_bank  (slot_bank),
  .ent_mode   (ent_mode),
  .ent_low    (ent_low),
  .out_data   (out_data),
  .out_en     (out_en)
);

// File: tb/test_tsi_switch_core.sv
module test_tsi_switch_core;

  localparam int NS  = 4;
  localparam int NCH = 8;
  localparam int CW  = 3;
  localparam int SW  = 2;
  localparam int AW  = SW + CW;
  localparam int LW  = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            frame_sync;
  logic [NS*8-1:0] in_data;
  logic            cpu_wr;
  logic            cpu_rd;
  logic [AW-1:0]   cpu_addr;
  logic [2:0]      cpu_wmode;
  logic [LW-1:0]   cpu_wlow;
  logic [2:0]      cpu_rmode;
  logic [LW-1:0]   cpu_rlow;
  logic [NS*8-1:0] out_data;
  logic [NS-1:0]   out_en;

  always #2 clk = ~clk;

  tsi_switch_core #(.NUM_STREAMS(NS), .NUM_CHANS(NCH)) i_tsi_switch_core (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .in_data(in_data),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wmode(cpu_wmode), .cpu_wlow(cpu_wlow),
    .cpu_rmode(cpu_rmode), .cpu_rlow(cpu_rlow),
    .out_data(out_data), .out_en(out_en)
  );

  // reference model, built from the requirements
  int m_mode [NS*NCH];
  int m_low  [NS*NCH];
  int m_dm   [3][NS][NCH];
  int m_ch;
  int m_bank;

  int    checks = 0;
  int    errors = 0;
  string ctx = "reset";
  bit    done = 1'b0;

  function automatic int bnext(int b); return (b + 1) % 3; endfunction
  function automatic int bprev(int b); return (b + 2) % 3; endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s]: got %0h expected %0h", tag, ctx, act, exp);
    end
  endtask

  // expected output of one stream for slot cc of bank cb
  task automatic expect_out(int s, int cc, int cb, output int eb, output int ee, output string tag);
    int idx, md, lw, sch, sst, bk;
    idx = s * NCH + cc;
    md  = m_mode[idx];
    lw  = m_low[idx];
    sch = lw % NCH;
    sst = (lw / NCH) % NS;
    ee  = 1;
    case (md)
      0: begin
        bk  = (sch + 3 <= cc) ? cb : bprev(cb);
        eb  = m_dm[bk][sst][sch];
        tag = "R8 R9 R3";
      end
      1: begin
        eb  = m_dm[bnext(cb)][sst][sch];
        tag = "R7 R9 R3";
      end
      4: begin eb = lw & 255; tag = "R5"; end
      5: begin eb = (cc % 2 == 1) ? 8'hAA : 8'h55; tag = "R6"; end
      7: begin eb = 0; ee = 0; tag = "R4"; end
      default: begin eb = 8'hFF; tag = "R10"; end
    endcase
  endtask

  task automatic step(bit fs, bit wr, bit rd, int addr, int wmode, int wlow);
    int    cc, cb, erm, erl;
    int    din [NS];
    int    eb  [NS];
    int    ee  [NS];
    string et  [NS];
    cc = fs ? 0 : m_ch;
    cb = (fs && m_ch != 0) ? bnext(m_bank) : m_bank;
    for (int s = 0; s < NS; s++) begin
      din[s] = int'($urandom % 256);
      in_data[s*8 +: 8] = 8'(din[s]);
    end
    frame_sync = fs;
    cpu_wr     = wr;
    cpu_rd     = rd;
    cpu_addr   = AW'(addr);
    cpu_wmode  = 3'(wmode);
    cpu_wlow   = LW'(wlow);
    for (int s = 0; s < NS; s++) expect_out(s, cc, cb, eb[s], ee[s], et[s]);
    erm = m_mode[addr];
    erl = m_low[addr];
    @(posedge clk);
    for (int s = 0; s < NS; s++) m_dm[cb][s][cc] = din[s];
    if (wr) begin
      m_mode[addr] = wmode % 8;
      m_low[addr]  = wlow % 256;
    end
    m_ch   = (cc == NCH - 1) ? 0 : cc + 1;
    m_bank = (cc == NCH - 1) ? bnext(cb) : cb;
    #1;
    for (int s = 0; s < NS; s++) begin
      check({et[s], " en"}, int'(out_en[s]), ee[s]);
      check({et[s], " data"}, int'(out_data[s*8 +: 8]), eb[s]);
    end
    if (rd) begin
      check("R12 mode", int'(cpu_rmode), erm);   // R12: old contents
      check("R12 low", int'(cpu_rlow), erl);
    end
    frame_sync = 1'b0;
    cpu_wr     = 1'b0;
    cpu_rd     = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfg(int addr, int mode, int low);
    step(1'b0, 1'b1, 1'b0, addr, mode, low);
  endtask

  task automatic run_frames(int n, bit with_fs, bit rnd);
    int pick [10] = '{0, 0, 0, 1, 1, 4, 5, 7, 3, 6};
    for (int f = 0; f < n; f++) begin
      for (int k = 0; k < NCH; k++) begin
        bit wr, rd;
        wr = rnd && ($urandom % 4 == 0);
        rd = rnd && ($urandom % 4 == 0);
        step(with_fs && k == 0, wr, rd, int'($urandom % (NS * NCH)),
             pick[$urandom % 10], int'($urandom % 256));
      end
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog [%s]: got timeout expected completion", ctx);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7719));
    for (int i = 0; i < NS * NCH; i++) begin m_mode[i] = 7; m_low[i] = 0; end
    for (int b = 0; b < 3; b++)
      for (int s = 0; s < NS; s++)
        for (int c = 0; c < NCH; c++) m_dm[b][s][c] = 0;
    m_ch = 0; m_bank = 0;
    rst_n = 1'b0; frame_sync = 1'b0; in_data = '0;
    cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_addr = '0; cpu_wmode = '0; cpu_wlow = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13: reset state at the ports
    check("R13 out_en", int'(out_en), 0);
    check("R13 out_data", int'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    ctx = "R13 entry after reset";
    step(1'b1, 1'b0, 1'b1, 5, 0, 0);
    ctx = "all off";
    run_frames(1, 1'b1, 1'b0);

    // directed connections
    ctx = "directed setup";
    cfg(0 * NCH + 7, 0, (1 << CW) | 4);   // var, src+3 == dst: same frame
    cfg(0 * NCH + 6, 0, (1 << CW) | 4);   // var, src+2 == dst: previous frame
    cfg(0 * NCH + 2, 1, (2 << CW) | 2);   // constant delay
    cfg(1 * NCH + 5, 0, (3 << CW) | 0);   // R9: two outputs share one source
    cfg(1 * NCH + 6, 0, (3 << CW) | 0);
    cfg(2 * NCH + 3, 4, 8'h3C);
    cfg(3 * NCH + 1, 5, 0);
    cfg(3 * NCH + 2, 5, 0);
    cfg(2 * NCH + 0, 2, 0);
    cfg(2 * NCH + 4, 6, 0);
    cfg(1 * NCH + 0, 0, (1 << CW) | 7);   // var, source after destination
    ctx = "directed run";
    run_frames(6, 1'b1, 1'b0);

    // R11: write in the entry's own slot, then the slot right after
    ctx = "R11 write timing";
    for (int k = 0; k < 2 * NCH; k++) begin
      if (k == 3)      step(1'b0, 1'b1, 1'b0, 1 * NCH + m_ch, 4, 8'h5A);
      else if (k == 4) step(1'b0, 1'b1, 1'b1, 2 * NCH + ((m_ch + 1) % NCH), 4, 8'hC3);
      else             step(1'b0, 1'b0, 1'b0, 0, 0, 0);
    end

    // R2: frame pulse arriving before the natural wrap
    ctx = "R2 early frame pulse";
    run_frames(1, 1'b1, 1'b0);
    for (int k = 0; k < 5; k++) step(1'b0, 1'b0, 1'b0, 0, 0, 0);
    run_frames(3, 1'b1, 1'b0);

    ctx = "R1 free-running wrap";
    run_frames(3, 1'b0, 1'b0);

    ctx = "random";
    run_frames(30, 1'b1, 1'b1);
    ctx = "random free-running";
    run_frames(6, 1'b0, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule